// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Transmitter

This block turns one character into one asynchronous serial frame on a single output line. A frame is a low start bit, the data bits least significant first, an optional parity bit or ninth data bit, and one or two high stop bits. The caller sets the frame shape on configuration inputs: 7, 8 or 9 data bits, one or two stop bits, parity on or off, and a parity rule. The parity rule is odd, even, constant one or constant zero.

Bit timing comes from outside the block as a one-cycle tick, one tick per bit period. A start strobe is accepted only while the block is ready. At that moment the block takes a copy of the character and the frame shape, and it holds that copy until the last stop bit has gone out. A separate break control pulls the line low for as long as it is set. The frame sequencing keeps running underneath it.

Top module: `uart_txf`

## Requirements
- R1: After reset, and whenever no frame is in flight, `txd_o` is 1, `busy_o` is 0 and `ready_o` is 1 (with `brk_i` low). `ready_o` is always the inverse of `busy_o`.
- R2: A `start_i` pulse while `ready_o` is 1 makes `busy_o` 1 from the next cycle. `txd_o` then carries the low start bit until the next `baud_tick_i`. Every later bit also lasts from one tick to the next.
- R3: `len_i` selects the data length: 2'b00 gives 7 bits, 2'b01 gives 8 bits, 2'b10 gives 9 bits and 2'b11 gives 8 bits. Data bits are sent least significant first, from `data_i[0]` upward.
- R4: In 9-bit mode the ninth data bit, sent after `data_i[7]`, is `tx9_i`. In 7-bit and 8-bit modes `tx9_i` has no effect on the line.
- R5: One parity bit follows the data bits only when `par_en_i` is 1 and the mode is not 9-bit. In 9-bit mode `par_en_i` and `par_sel_i` have no effect.
- R6: `par_sel_i` sets the parity bit. 2'b00 (odd) makes the number of ones in the data bits plus parity odd. 2'b01 (even) makes it even. 2'b10 sends 1. 2'b11 sends 0.
- R7: `stop2_i` = 0 sends one high stop bit and 1 sends two. `busy_o` stays 1 through the last stop bit and falls on the tick that ends it.
- R8: A `start_i` pulse while `busy_o` is 1 is ignored and does not alter the frame in flight.
- R9: Data, ninth bit and configuration are captured when the start is accepted. Changes to them during the frame do not alter it.
- R10: While `brk_i` is 1, `txd_o` is 0 whatever the frame state. Frame timing and `busy_o` carry on unchanged, and the line returns to its normal value once `brk_i` clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick_i | input | 1 | One-cycle pulse marking the end of a bit period |
| start_i | input | 1 | Request to send one frame |
| data_i | input | 8 | Character data, bit 0 sent first |
| tx9_i | input | 1 | Ninth data bit for 9-bit mode |
| len_i | input | 2 | Data length select |
| stop2_i | input | 1 | Two stop bits when 1 |
| par_en_i | input | 1 | Parity bit enable |
| par_sel_i | input | 2 | Parity rule select |
| brk_i | input | 1 | Force line low |
| txd_o | output | 1 | Serial line |
| busy_o | output | 1 | Frame in flight |
| ready_o | output | 1 | Start request will be accepted |

## Verification
The assertions assume that a bit advances only on a cycle in which `baud_tick_i` is high. They also assume a captured frame always begins with a low start bit and ends with a high stop bit. The stimulus keeps ticks one cycle wide with at least one idle cycle between them. It raises stray starts and scrambles every data and configuration input only in tick-free cycles inside a frame, so the hold properties are exercised and never contradicted. The bench sweeps every length code, stop count, parity enable and parity rule, over several data patterns with both ninth-bit values.

// File: rtl/uart_txf_pkg.sv
package uart_txf_pkg;

    localparam int BYTE_W   = 8;
    localparam int WORD_W   = BYTE_W + 1;
    localparam int FRAME_W  = 1 + WORD_W + 2;
    localparam int CNT_W    = $clog2(FRAME_W + 1);

    typedef enum logic [1:0] {
        LEN_7   = 2'b00,
        LEN_8   = 2'b01,
        LEN_9   = 2'b10,
        LEN_RSV = 2'b11
    } len_e;

    typedef enum logic [1:0] {
        PAR_ODD   = 2'b00,
        PAR_EVEN  = 2'b01,
        PAR_MARK  = 2'b10,
        PAR_SPACE = 2'b11
    } par_e;

    typedef struct packed {
        len_e len;
        logic stop2;
        logic par_en;
        par_e psel;
    } txcfg_t;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;
        logic [CNT_W-1:0]   nbits;
    } frame_t;

    function automatic int unsigned data_count(len_e l);
        case (l)
            LEN_7:   return 7;
            LEN_9:   return 9;
            default: return 8;
        endcase
    endfunction

    function automatic logic parity_used(txcfg_t c);
        return c.par_en && (c.len != LEN_9);
    endfunction

endpackage

// File: rtl/uart_txf_parity.sv
module uart_txf_parity
    import uart_txf_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    input  len_e              len_i,
    input  par_e              psel_i,
    output logic              par_o
);
    logic [WORD_W-1:0] mask;
    logic              ones_odd;

    always_comb begin
        for (int i = 0; i < WORD_W; i++) begin
            mask[i] = (i < data_count(len_i));
        end
        ones_odd = ^(word_i & mask);
        case (psel_i)
            PAR_ODD:  par_o = ~ones_odd;
            PAR_EVEN: par_o = ones_odd;
            PAR_MARK: par_o = 1'b1;
            default:  par_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/uart_txf_build.sv
module uart_txf_build
    import uart_txf_pkg::*;
(
    input  logic [BYTE_W-1:0] data_i,
    input  logic              tx9_i,
    input  txcfg_t            cfg_i,
    output frame_t            frame_o
);
    logic [WORD_W-1:0] word;
    logic              par_bit;
    logic              has_par;
    int unsigned       nd;

    assign word = {tx9_i, data_i};

    uart_txf_parity u_par (
        .word_i (word),
        .len_i  (cfg_i.len),
        .psel_i (cfg_i.psel),
        .par_o  (par_bit)
    );

    always_comb begin
        nd      = data_count(cfg_i.len);
        has_par = parity_used(cfg_i);
        for (int j = 0; j < FRAME_W; j++) begin
            if (j == 0)
                frame_o.bits[j] = 1'b0;
            else if (j <= nd)
                frame_o.bits[j] = word[j-1];
            else if (has_par && (j == nd + 1))
                frame_o.bits[j] = par_bit;
            else
                frame_o.bits[j] = 1'b1;
        end
        frame_o.nbits = CNT_W'(1 + nd + (has_par ? 1 : 0) + (cfg_i.stop2 ? 2 : 1));
    end
endmodule

// File: rtl/uart_txf_serial.sv
module uart_txf_serial
    import uart_txf_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start_i,
    input  logic   tick_i,
    input  frame_t frame_i,
    output logic   line_o,
    output logic   busy_o
);
    logic [FRAME_W-1:0] sh_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '1;
            cnt_q  <= '0;
            busy_q <= 1'b0;
        end else if (!busy_q && start_i) begin
            sh_q   <= frame_i.bits;
            cnt_q  <= frame_i.nbits;
            busy_q <= 1'b1;
        end else if (busy_q && tick_i) begin
            if (cnt_q == CNT_W'(1)) begin
                sh_q   <= '1;
                cnt_q  <= '0;
                busy_q <= 1'b0;
            end else begin
                sh_q  <= {1'b1, sh_q[FRAME_W-1:1]};
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

    assign line_o = sh_q[0];
    assign busy_o = busy_q;

    p_start_low_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q) |-> !sh_q[0]);

    p_last_stop_high_r7: assert property (@(posedge clk) disable iff (rst)
        busy_q && (cnt_q == CNT_W'(1)) |-> sh_q[0]);

    p_hold_no_tick_r8: assert property (@(posedge clk) disable iff (rst)
        busy_q && !tick_i |=> busy_q && $stable(sh_q) && $stable(cnt_q));

    p_idle_high_r1: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> sh_q[0] && (cnt_q == '0));
endmodule

// File: rtl/uart_txf.sv
module uart_txf
    import uart_txf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick_i,
    input  logic              start_i,
    input  logic [BYTE_W-1:0] data_i,
    input  logic              tx9_i,
    input  logic [1:0]        len_i,
    input  logic              stop2_i,
    input  logic              par_en_i,
    input  logic [1:0]        par_sel_i,
    input  logic              brk_i,
    output logic              txd_o,
    output logic              busy_o,
    output logic              ready_o
);
    txcfg_t cfg;
    frame_t frame;
    logic   line;

    assign cfg.len    = len_e'(len_i);
    assign cfg.stop2  = stop2_i;
    assign cfg.par_en = par_en_i;
    assign cfg.psel   = par_e'(par_sel_i);

    uart_txf_build u_build (
        .data_i  (data_i),
        .tx9_i   (tx9_i),
        .cfg_i   (cfg),
        .frame_o (frame)
    );

    uart_txf_serial u_serial (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .tick_i  (baud_tick_i),
        .frame_i (frame),
        .line_o  (line),
        .busy_o  (busy_o)
    );

    assign txd_o   = line & ~brk_i;
    assign ready_o = ~busy_o;

    p_break_low_r10: assert property (@(posedge clk) disable iff (rst)
        brk_i |-> !txd_o);

    p_ready_inv_r1: assert property (@(posedge clk) disable iff (rst)
        ready_o != busy_o);
endmodule

// File: tb/uart_txf_tb.sv
module uart_txf_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0, start = 1'b0, tx9 = 1'b0, stop2 = 1'b0, pen = 1'b0, brk = 1'b0;
    logic [7:0] data = '0;
    logic [1:0] len = '0, psel = '0;
    logic       txd, busy, ready;
    int         n_vec = 0, n_bad = 0;
    int         cycles = 0;
    bit         done = 0;

    always #2.5 clk = ~clk;

    uart_txf u_dut (
        .clk(clk), .rst(rst), .baud_tick_i(tick), .start_i(start),
        .data_i(data), .tx9_i(tx9), .len_i(len), .stop2_i(stop2),
        .par_en_i(pen), .par_sel_i(psel), .brk_i(brk),
        .txd_o(txd), .busy_o(busy), .ready_o(ready)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles, expected under 150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] d, input logic n9, input logic [1:0] l,
                        input logic s2, input logic pe, input logic [1:0] ps,
                        input logic bk);
        logic [19:0] exp_b, got_b;
        int nd, ones, k, nb;
        logic par;
        nd = (l == 2'b00) ? 7 : (l == 2'b10) ? 9 : 8;
        exp_b = '1;
        exp_b[0] = 1'b0;
        ones = 0;
        for (int i = 0; i < nd; i++) begin
            exp_b[1+i] = (i < 8) ? d[i] : n9;
            ones += (i < 8) ? int'(d[i]) : int'(n9);
        end
        k = 1 + nd;
        if (pe && l != 2'b10) begin
            case (ps)
                2'b00: par = (ones % 2 == 0);
                2'b01: par = (ones % 2 == 1);
                2'b10: par = 1'b1;
                default: par = 1'b0;
            endcase
            exp_b[k] = par;
            k++;
        end
        k += s2 ? 2 : 1;
        if (bk) exp_b = '0;
        @(negedge clk);
        data = d; tx9 = n9; len = l; stop2 = s2; pen = pe; psel = ps; brk = bk;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2 busy after start", int'(busy), 1);
        got_b = '1;
        nb = 0;
        while (busy && nb < 20) begin
            got_b[nb] = txd;
            nb++;
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            // R8 R9: stray start and scrambled inputs in a tick-free cycle
            data = ~d; tx9 = ~n9; len = l + 2'd1; stop2 = ~s2; pen = ~pe; psel = ps + 2'd1;
            start = busy;
            @(negedge clk);
            start = 1'b0;
        end
        chk("R3 R5 R7 R8 R9 R10 frame length", nb, k);
        for (int i = 0; i < k; i++)
            if (got_b[i] !== exp_b[i]) begin
                n_bad++;
                $display("FAIL R3 R4 R5 R6 R7 R9 R10 bit %0d: actual %b expected %b (len %0d ps %0d pe %0d)",
                         i, got_b[i], exp_b[i], l, ps, pe);
                break;
            end
        brk = 1'b0;
        @(negedge clk);
        chk("R1 idle line after frame", int'(txd), 1);
    endtask

    logic [7:0] pats [6] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80};

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset txd", int'(txd), 1);
        chk("R1 reset busy", int'(busy), 0);
        chk("R1 reset ready", int'(ready), 1);
        brk = 1'b1;
        @(negedge clk);
        chk("R10 idle break", int'(txd), 0);
        brk = 1'b0;
        @(negedge clk);
        chk("R10 break released", int'(txd), 1);
        // R2: start bit held without ticks
        start = 1'b1; data = 8'hFF; len = 2'b01; pen = 1'b0; stop2 = 1'b0;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        chk("R2 start bit held", int'(txd), 0);
        chk("R2 ready low while busy", int'(ready), 0);
        for (int b = 0; b < 10; b++) begin
            tick = 1'b1; @(negedge clk); tick = 1'b0; @(negedge clk);
        end
        chk("R7 busy cleared after stop", int'(busy), 0);
        for (int l = 0; l < 4; l++)
            for (int s = 0; s < 2; s++)
                for (int pe = 0; pe < 2; pe++)
                    for (int ps = 0; ps < 4; ps++)
                        for (int p = 0; p < 6; p++)
                            for (int n9 = 0; n9 < 2; n9++)
                                send(pats[p], n9[0], l[1:0], s[0], pe[0], ps[1:0], 1'b0);
        send(8'h3C, 1'b1, 2'b10, 1'b1, 1'b1, 2'b00, 1'b1);
        send(8'hC3, 1'b0, 2'b00, 1'b0, 1'b1, 2'b01, 1'b1);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule